// File: doc/BRIEF.md
# Priority Multiplexed Register Transfer

This block is a single destination register with two possible sources. Two source words arrive on input buses. A 2:1 selector picks one of them, and two control bits with a fixed priority decide whether the register loads at all. The primary control wins whenever it is asserted and selects source A. The secondary control applies only when the primary is low, and it selects source B. With both controls low, the register keeps its contents.

The load enable is the OR of the two controls, and the selector is steered by the primary control alone. The register value is presented on an output port. It updates on the rising clock edge that samples the controls. The data width is a parameter with a default of 4.

Top module: `prio_xfer_reg`

## Requirements
- R1: While rst_ni is low, dest_o is all zeros. Reset is asynchronous and overrides any transfer.
- R2: When pri_ctl_i is 1 at a rising edge, dest_o takes the value of src_a_i from that edge, whatever sec_ctl_i is.
- R3: When pri_ctl_i is 0 and sec_ctl_i is 1 at a rising edge, dest_o takes the value of src_b_i from that edge.
- R4: When both controls are 0 at a rising edge, dest_o keeps its value. Changes on src_a_i and src_b_i have no effect on it.
- R5: dest_o changes only at a rising clock edge. It shows the new value within the cycle after the edge that sampled the controls, and it stays steady while inputs change between edges.
- R6: The width WIDTH is a parameter of at least 1, shared by src_a_i, src_b_i and dest_o. A build with WIDTH=1 behaves per R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_ctl_i | input | 1 | Primary transfer control, selects source A |
| sec_ctl_i | input | 1 | Secondary transfer control, selects source B when primary is low |
| src_a_i | input | WIDTH | Source word A |
| src_b_i | input | WIDTH | Source word B |
| dest_o | output | WIDTH | Destination register contents |

## Verification
The two controls can both be high in the same cycle. When that happens, the primary must win. The bench asserts both controls together while giving the two sources different patterns, and it expects source A in the register after the edge. Reset can also meet a pending transfer: the bench drops rst_ni while a primary load is requested and expects zeros rather than source A. Hold is judged by changing both sources while the controls are low and confirming the output is unchanged.

// File: rtl/prio_xfer_pkg.sv
package prio_xfer_pkg;
  localparam int unsigned DEF_WIDTH = 4;
  typedef enum logic [1:0] {
    XFER_HOLD  = 2'b00,
    XFER_SRC_B = 2'b01,
    XFER_SRC_A = 2'b10
  } xfer_op_e;
endpackage

// File: rtl/prio_xfer_ctrl.sv
module prio_xfer_ctrl
  import prio_xfer_pkg::*;
(
  input  logic pri_ctl_i,
  input  logic sec_ctl_i,
  output logic load_en_o,
  output logic sel_a_o
);
  xfer_op_e op;

  always_comb begin
    if (pri_ctl_i)      op = XFER_SRC_A;
    else if (sec_ctl_i) op = XFER_SRC_B;
    else                op = XFER_HOLD;
  end

  assign load_en_o = (op != XFER_HOLD);
  assign sel_a_o   = (op == XFER_SRC_A);
endmodule

// File: rtl/prio_xfer_mux.sv
module prio_xfer_mux #(
  parameter int unsigned WIDTH = prio_xfer_pkg::DEF_WIDTH
) (
  input  logic             sel_a_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y_o[i] = sel_a_i ? a_i[i] : b_i[i];
  end
endmodule

// File: rtl/prio_xfer_dreg.sv
module prio_xfer_dreg #(
  parameter int unsigned WIDTH = prio_xfer_pkg::DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] RST_VAL = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/prio_xfer_reg.sv
module prio_xfer_reg #(
  parameter int unsigned WIDTH = prio_xfer_pkg::DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pri_ctl_i,
  input  logic             sec_ctl_i,
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] src_b_i,
  output logic [WIDTH-1:0] dest_o
);
  logic             load_en;
  logic             sel_a;
  logic [WIDTH-1:0] mux_y;

  prio_xfer_ctrl u_ctrl (
    .pri_ctl_i (pri_ctl_i),
    .sec_ctl_i (sec_ctl_i),
    .load_en_o (load_en),
    .sel_a_o   (sel_a)
  );

  prio_xfer_mux #(.WIDTH(WIDTH)) u_mux (
    .sel_a_i (sel_a),
    .a_i     (src_a_i),
    .b_i     (src_b_i),
    .y_o     (mux_y)
  );

  prio_xfer_dreg #(.WIDTH(WIDTH)) u_dreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_en),
    .d_i    (mux_y),
    .q_o    (dest_o)
  );
endmodule

// File: rtl/prio_xfer_reg_chk.sv
module prio_xfer_reg_chk #(
  parameter int unsigned WIDTH = prio_xfer_pkg::DEF_WIDTH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pri_ctl_i,
  input logic             sec_ctl_i,
  input logic [WIDTH-1:0] src_a_i,
  input logic [WIDTH-1:0] src_b_i,
  input logic [WIDTH-1:0] dest_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (dest_o == '0);
    end
  end

  // R2
  pri_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_ctl_i |=> dest_o == $past(src_a_i));

  // R3
  sec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pri_ctl_i && sec_ctl_i) |=> dest_o == $past(src_b_i));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pri_ctl_i && !sec_ctl_i) |=> $stable(dest_o));
endmodule

bind prio_xfer_reg prio_xfer_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pri_ctl_i (pri_ctl_i),
  .sec_ctl_i (sec_ctl_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .dest_o    (dest_o)
);

// File: tb/sim_prio_xfer_reg.sv
module sim_prio_xfer_reg;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pri = 1'b0, sec = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] dq;
  logic         pri1 = 1'b0, sec1 = 1'b0, a1 = 1'b0, b1 = 1'b0;
  logic         dq1;
  int           checks = 0;
  int           errors = 0;
  logic [W-1:0] exp_q = '0;

  always #10 clk = ~clk;

  prio_xfer_reg #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pri_ctl_i(pri), .sec_ctl_i(sec),
    .src_a_i(a), .src_b_i(b), .dest_o(dq)
  );

  prio_xfer_reg #(.WIDTH(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .pri_ctl_i(pri1), .sec_ctl_i(sec1),
    .src_a_i(a1), .src_b_i(b1), .dest_o(dq1)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dest=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic p, input logic s, input logic [W-1:0] va, input logic [W-1:0] vb);
    @(negedge clk);
    pri = p; sec = s; a = va; b = vb;
    if (p) exp_q = va;
    else if (s) exp_q = vb;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #5;
    chk("R1 reset value", dq, '0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_q = '0;
  endtask

  task automatic t_pri();
    step(1'b1, 1'b0, 4'hA, 4'h5); chk("R2 primary only", dq, exp_q);
    step(1'b1, 1'b1, 4'h3, 4'hC); chk("R2 both set, primary wins", dq, 4'h3);
    step(1'b1, 1'b1, 4'hF, 4'h0); chk("R2 both set, all ones", dq, 4'hF);
  endtask

  task automatic t_sec();
    step(1'b0, 1'b1, 4'h1, 4'h6); chk("R3 secondary load", dq, 4'h6);
    step(1'b0, 1'b1, 4'hE, 4'h9); chk("R3 secondary load 2", dq, 4'h9);
  endtask

  task automatic t_hold();
    step(1'b0, 1'b0, 4'h0, 4'h0); chk("R4 hold", dq, 4'h9);
    step(1'b0, 1'b0, 4'hF, 4'hF); chk("R4 hold, sources changed", dq, 4'h9);
    step(1'b0, 1'b0, 4'h2, 4'h7); chk("R4 hold again", dq, exp_q);
  endtask

  task automatic t_timing();
    @(negedge clk);
    pri = 1'b1; a = 4'h4; b = 4'hB;
    #2;
    chk("R5 no change before edge", dq, 4'h9);
    @(negedge clk);
    chk("R5 updated after edge", dq, 4'h4);
    pri = 1'b0; sec = 1'b0; a = 4'h8;
    #3;
    chk("R5 stable mid-cycle", dq, 4'h4);
  endtask

  task automatic t_reset_vs_load();
    @(negedge clk);
    pri = 1'b1; a = 4'hD;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 reset overrides transfer", dq, '0);
    @(negedge clk);
    pri = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 hold after reset release", dq, '0);
  endtask

  task automatic t_narrow();
    @(negedge clk);
    pri1 = 1'b1; sec1 = 1'b1; a1 = 1'b1; b1 = 1'b0;
    @(posedge clk); #1;
    chk("R6 width1 primary", {3'b0, dq1}, 4'h1);
    @(negedge clk);
    pri1 = 1'b0; sec1 = 1'b1; a1 = 1'b1; b1 = 1'b0;
    @(posedge clk); #1;
    chk("R6 width1 secondary", {3'b0, dq1}, 4'h0);
    @(negedge clk);
    pri1 = 1'b0; sec1 = 1'b0; a1 = 1'b1; b1 = 1'b1;
    @(posedge clk); #1;
    chk("R6 width1 hold", {3'b0, dq1}, 4'h0);
  endtask

  initial begin
    t_reset();
    t_pri();
    t_sec();
    t_hold();
    t_timing();
    t_reset_vs_load();
    t_narrow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule